// File: doc/BRIEF.md
# Batched Streaming Complex FIR Engine

This block filters a stream of complex fixed-point samples through a direct-form FIR structure. One sample enters and one complex result leaves per accepted clock. It serves a batch of independent filter jobs that are joined end to end into a single input stream, and each job brings its own tap set. The datapath never needs nested-loop control, because the stream itself carries the job boundaries. Each job follows this stream layout:

1. A `job_start` pulse opens a coefficient-load window.
2. During that window, tap values arrive several lanes at a time. Zero samples are fed in parallel with them.
3. The job's samples follow.
4. The samples end with TAPS-1 zero samples. These carry the convolution tail out of the tap line.

A job of N samples therefore yields N+TAPS-1 meaningful results, and the next job can start at once.

Products are full complex multiplies. They are summed at full precision, and the output is an arithmetic right shift of the sum cut to a chosen width.

Top module: `cfir_batch_engine`

## Requirements
- R1: `out_valid` is high exactly in the clock cycle after a cycle with `in_valid` high, and low otherwise; the output data words change only after accepted samples.
- R2: For accepted sample history x (newest x[n]), the result is the sum over j=0..TAPS-1 of x[n-j]*c[j] as a full complex product: re = xr*cr - xi*ci and im = xr*ci + xi*cr. The newest sample pairs with tap 0.
- R3: Products and sums are kept at full precision. Each output word equals the full sum arithmetically shifted right by OUT_SHIFT and cut to OUT_W bits. This holds for extreme inputs such as -32768.
- R4: The tap history moves only on cycles with `in_valid` high. Idle cycles between samples leave the results unchanged.
- R5: A `job_start` pulse opens a window of TAPS/LANES chunk writes. Chunk number c, lane l, loads tap c*LANES+l. Lane l occupies bits [16*l+15:16*l] of `coef_re` and `coef_im`. The window stays open until its last chunk, even across cycles without `coef_valid`.
- R6: `coef_valid` outside a load window has no effect on the taps.
- R7: A `job_start` inside an open window restarts it at chunk 0. A chunk presented in the same cycle as `job_start` is discarded.
- R8: A sample accepted in the same cycle as a chunk write is filtered with the taps as they stood before that write.
- R9: Reset clears the tap history, all taps, `out_valid` and the output words.
- R10: Feeding TAPS/LANES zero pads during the load and TAPS-1 zeros after N samples yields the full linear convolution of N+TAPS-1 points. Pad results are zero, and the previous job's tail does not leak into them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| job_start | input | 1 | Opens (or restarts) the coefficient-load window |
| coef_valid | input | 1 | A coefficient chunk is present |
| coef_re | input | LANES*16 | Real parts of one chunk, lane l at bits 16*l upward |
| coef_im | input | LANES*16 | Imaginary parts of one chunk, same lane layout |
| in_valid | input | 1 | A sample is present |
| in_re | input | 16 | Sample real part, signed |
| in_im | input | 16 | Sample imaginary part, signed |
| out_valid | output | 1 | Result present, one cycle after the sample |
| out_re | output | OUT_W | Result real part, signed |
| out_im | output | OUT_W | Result imaginary part, signed |

## Verification
Coefficient chunk writes and sample shifts share a clock during every load window, because zero pads stream in alongside the chunks. The bench also forces a non-zero impulse into the first chunk cycle of a reload.

The impulse result is then judged twice:
- Its first result must show the old tap 0.
- Its second result must show the freshly written tap 1.

Both values come from a convolution model in the bench that applies chunk writes only after computing each result.

// File: rtl/cfir_pkg.sv
package cfir_pkg;
  localparam int CF_DW = 16;
  localparam int CF_PW = 2 * CF_DW + 1;

  typedef logic signed [CF_DW-1:0] cf_word_t;

  typedef struct packed {
    cf_word_t re;
    cf_word_t im;
  } cf_cplx_t;

  typedef struct packed {
    logic signed [CF_PW-1:0] re;
    logic signed [CF_PW-1:0] im;
  } cf_prod_t;

  // full-precision complex product
  function automatic cf_prod_t cf_cmul(input cf_cplx_t a, input cf_cplx_t b);
    cf_prod_t p;
    p.re = (CF_PW'(a.re) * CF_PW'(b.re)) - (CF_PW'(a.im) * CF_PW'(b.im));
    p.im = (CF_PW'(a.re) * CF_PW'(b.im)) + (CF_PW'(a.im) * CF_PW'(b.re));
    return p;
  endfunction
endpackage

// File: rtl/cfir_coef_bank.sv
module cfir_coef_bank
  import cfir_pkg::*;
#(
  parameter int TAPS  = 8,
  parameter int LANES = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      job_start,
  input  logic                      coef_valid,
  input  logic [LANES*CF_DW-1:0]    coef_re,
  input  logic [LANES*CF_DW-1:0]    coef_im,
  output cf_cplx_t [TAPS-1:0]       coef,
  output logic                      load_busy
);
  localparam int CHUNKS = TAPS / LANES;
  localparam int CW     = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;

  logic [CW-1:0] chunk_idx;
  logic          chunk_we;
  logic          last_chunk;
  cf_cplx_t      bank [TAPS];

  assign chunk_we   = coef_valid && load_busy && !job_start;
  assign last_chunk = (chunk_idx == CW'(CHUNKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_busy <= 1'b0;
      chunk_idx <= '0;
    end else if (job_start) begin
      load_busy <= 1'b1;
      chunk_idx <= '0;
    end else if (chunk_we) begin
      if (last_chunk) begin
        load_busy <= 1'b0;
        chunk_idx <= '0;
      end else begin
        chunk_idx <= chunk_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < TAPS; t++) bank[t] <= '0;
    end else if (chunk_we) begin
      for (int c = 0; c < CHUNKS; c++) begin
        if (chunk_idx == CW'(c)) begin
          for (int l = 0; l < LANES; l++) begin
            bank[c*LANES+l].re <= coef_re[l*CF_DW +: CF_DW];
            bank[c*LANES+l].im <= coef_im[l*CF_DW +: CF_DW];
          end
        end
      end
    end
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_out
    assign coef[t] = bank[t];
  end

  assert_window_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_busy) |-> $past(job_start));
  assert_window_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_we && last_chunk) |=> !load_busy);
  assert_stray_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (coef_valid && !load_busy && !job_start) |=> $stable(coef));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    job_start |=> (load_busy && chunk_idx == '0));
endmodule

// File: rtl/cfir_tap_line.sv
module cfir_tap_line
  import cfir_pkg::*;
#(
  parameter int TAPS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  cf_cplx_t            sample,
  output cf_cplx_t [TAPS-1:0] taps_next,
  output cf_cplx_t [TAPS-1:0] taps_q
);
  always_comb begin
    taps_next = taps_q;
    if (in_valid) begin
      for (int i = 0; i < TAPS - 1; i++) taps_next[i] = taps_q[i+1];
      taps_next[TAPS-1] = sample;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) taps_q <= '0;
    else        taps_q <= taps_next;
  end

  assert_newest_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> taps_q[TAPS-1] == $past(sample));
  assert_oldest_moves_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> taps_q[0] == $past(taps_q[1]));
  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(taps_q));
endmodule

// File: rtl/cfir_dot.sv
module cfir_dot
  import cfir_pkg::*;
#(
  parameter int TAPS      = 8,
  parameter int OUT_W     = 32,
  parameter int OUT_SHIFT = 4
) (
  input  cf_cplx_t [TAPS-1:0]      taps,
  input  cf_cplx_t [TAPS-1:0]      coef,
  output logic signed [OUT_W-1:0]  y_re,
  output logic signed [OUT_W-1:0]  y_im
);
  localparam int ACC_W = CF_PW + $clog2(TAPS);

  cf_prod_t                 prods [TAPS];
  logic signed [ACC_W-1:0]  acc_re;
  logic signed [ACC_W-1:0]  acc_im;

  // newest sample (top index) meets tap 0
  for (genvar j = 0; j < TAPS; j++) begin : g_mul
    assign prods[j] = cf_cmul(taps[TAPS-1-j], coef[j]);
  end

  always_comb begin
    acc_re = '0;
    acc_im = '0;
    for (int j = 0; j < TAPS; j++) begin
      acc_re = acc_re + ACC_W'(prods[j].re);
      acc_im = acc_im + ACC_W'(prods[j].im);
    end
  end

  assign y_re = OUT_W'(acc_re >>> OUT_SHIFT);
  assign y_im = OUT_W'(acc_im >>> OUT_SHIFT);
endmodule

// File: rtl/cfir_batch_engine.sv
module cfir_batch_engine
  import cfir_pkg::*;
#(
  parameter int TAPS      = 8,
  parameter int LANES     = 4,
  parameter int OUT_W     = 32,
  parameter int OUT_SHIFT = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     job_start,
  input  logic                     coef_valid,
  input  logic [LANES*CF_DW-1:0]   coef_re,
  input  logic [LANES*CF_DW-1:0]   coef_im,
  input  logic                     in_valid,
  input  logic signed [CF_DW-1:0]  in_re,
  input  logic signed [CF_DW-1:0]  in_im,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_re,
  output logic signed [OUT_W-1:0]  out_im
);
  cf_cplx_t [TAPS-1:0]     coef;
  cf_cplx_t [TAPS-1:0]     taps_next;
  cf_cplx_t [TAPS-1:0]     taps_q;
  cf_cplx_t                sample;
  logic                    load_busy;
  logic signed [OUT_W-1:0] y_re;
  logic signed [OUT_W-1:0] y_im;

  assign sample.re = in_re;
  assign sample.im = in_im;

  cfir_coef_bank #(.TAPS(TAPS), .LANES(LANES)) u_bank (
    .clk(clk), .rst_n(rst_n), .job_start(job_start), .coef_valid(coef_valid),
    .coef_re(coef_re), .coef_im(coef_im), .coef(coef), .load_busy(load_busy)
  );

  cfir_tap_line #(.TAPS(TAPS)) u_line (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sample(sample),
    .taps_next(taps_next), .taps_q(taps_q)
  );

  // taps after this cycle's shift, taps before this cycle's chunk write
  cfir_dot #(.TAPS(TAPS), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) u_dot (
    .taps(taps_next), .coef(coef), .y_re(y_re), .y_im(y_im)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_re <= y_re;
        out_im <= y_im;
      end
    end
  end

  assert_result_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_data_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_re) && $stable(out_im)));
  assert_window_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_busy && !job_start && !coef_valid) |=> load_busy);
endmodule

// File: tb/cfir_batch_engine_test.sv
module cfir_batch_engine_test;
  localparam int TAPS = 8, LANES = 4, OUT_W = 32, OUT_SHIFT = 4;
  localparam int CHUNKS = TAPS / LANES, JOB_N = 5, JOBS = 2, LOG_MAX = 512;

  logic clk = 1'b0;
  logic rst_n, job_start, coef_valid, in_valid, out_valid;
  logic [LANES*16-1:0] coef_re, coef_im;
  logic signed [15:0] in_re, in_im;
  logic signed [OUT_W-1:0] out_re, out_im;

  always #5 clk = ~clk;

  cfir_batch_engine #(.TAPS(TAPS), .LANES(LANES), .OUT_W(OUT_W), .OUT_SHIFT(OUT_SHIFT)) uut (
    .clk(clk), .rst_n(rst_n), .job_start(job_start), .coef_valid(coef_valid),
    .coef_re(coef_re), .coef_im(coef_im), .in_valid(in_valid), .in_re(in_re),
    .in_im(in_im), .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  // stimulus table: {re, im} per entry
  localparam logic [31:0] JOB_X [JOBS*JOB_N] = '{
    {16'sd100, -16'sd50}, {16'sd7, 16'sd300}, {-16'sd1200, 16'sd0}, {16'sd55, 16'sd55}, {-16'sd3, -16'sd900},
    {16'sd2000, 16'sd1}, {-16'sd400, 16'sd250}, {16'sd0, -16'sd77}, {16'sd31000, -16'sd31000}, {16'sd9, 16'sd12}
  };
  localparam logic [31:0] JOB_C [JOBS*TAPS] = '{
    {16'sd3, 16'sd0}, {16'sd1, -16'sd2}, {-16'sd5, 16'sd4}, {16'sd10, 16'sd1},
    {16'sd0, 16'sd7}, {-16'sd8, -16'sd8}, {16'sd2, 16'sd2}, {16'sd100, -16'sd1},
    {-16'sd500, 16'sd20}, {16'sd64, 16'sd64}, {16'sd1, 16'sd0}, {-16'sd3, 16'sd9},
    {16'sd250, -16'sd125}, {16'sd0, 16'sd0}, {16'sd11, -16'sd13}, {-16'sd1, 16'sd1}
  };

  int errors = 0, checks = 0;
  bit done = 0;
  int m_busy = 0, m_cnt = 0, log_len = 0;
  int m_cre [TAPS], m_cim [TAPS];
  int log_re [LOG_MAX], log_im [LOG_MAX];
  int src_re [TAPS], src_im [TAPS];

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [LANES*16-1:0] pack_lane(input int c, input bit imag);
    logic [LANES*16-1:0] v;
    for (int l = 0; l < LANES; l++)
      v[l*16 +: 16] = 16'(imag ? src_im[c*LANES+l] : src_re[c*LANES+l]);
    return v;
  endfunction

  // one clock: drive, convolve with pre-edge taps, update tap model, check
  task automatic step(input bit js, input bit cv, input bit iv, input int xr, input int xi,
                      input logic [LANES*16-1:0] cr, input logic [LANES*16-1:0] ci,
                      input string tag);
    longint sr, si;
    logic signed [OUT_W-1:0] er, ei;
    job_start = js; coef_valid = cv; coef_re = cr; coef_im = ci;
    in_valid = iv; in_re = 16'(xr); in_im = 16'(xi);
    @(posedge clk);
    if (iv) begin
      log_re[log_len] = xr; log_im[log_len] = xi; log_len++;
    end
    sr = 0; si = 0;
    for (int j = 0; j < TAPS; j++) begin
      int k = log_len - 1 - j;
      if (k >= 0) begin
        sr += longint'(log_re[k]) * m_cre[j] - longint'(log_im[k]) * m_cim[j];
        si += longint'(log_re[k]) * m_cim[j] + longint'(log_im[k]) * m_cre[j];
      end
    end
    if (js) begin
      m_busy = 1; m_cnt = 0;
    end else if (cv && m_busy != 0) begin
      for (int l = 0; l < LANES; l++) begin
        m_cre[m_cnt*LANES+l] = $signed(cr[l*16 +: 16]);
        m_cim[m_cnt*LANES+l] = $signed(ci[l*16 +: 16]);
      end
      m_cnt++;
      if (m_cnt == CHUNKS) begin m_busy = 0; m_cnt = 0; end
    end
    @(negedge clk);
    chk({tag, " R1 valid"}, longint'(out_valid), longint'(iv));
    if (iv) begin
      er = OUT_W'(sr >>> OUT_SHIFT);
      ei = OUT_W'(si >>> OUT_SHIFT);
      chk({tag, " re"}, longint'(out_re), longint'(er));
      chk({tag, " im"}, longint'(out_im), longint'(ei));
    end
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, '0, '0, tag);
  endtask

  task automatic sample(input int xr, input int xi, input string tag);
    step(0, 0, 1, xr, xi, '0, '0, tag);
  endtask

  task automatic load_set(input string tag);
    step(1, 0, 0, 0, 0, '0, '0, tag);
    for (int c = 0; c < CHUNKS; c++)
      step(0, 1, 1, 0, 0, pack_lane(c, 0), pack_lane(c, 1), tag);
  endtask

  task automatic impulse(input string tag);
    sample(16, 0, tag);
    for (int i = 0; i < TAPS - 1; i++) sample(0, 0, tag);
  endtask

  task automatic flush(input string tag);
    for (int i = 0; i < TAPS; i++) sample(0, 0, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; job_start = 0; coef_valid = 0; in_valid = 0;
    coef_re = '0; coef_im = '0; in_re = '0; in_im = '0;
    for (int t = 0; t < TAPS; t++) begin m_cre[t] = 0; m_cim[t] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset valid", longint'(out_valid), 0);
    chk("R9 reset re", longint'(out_re), 0);
    chk("R9 reset im", longint'(out_im), 0);
    rst_n = 1;

    // table walk: each job reloads taps, streams samples, drains tail
    for (int jb = 0; jb < JOBS; jb++) begin
      for (int t = 0; t < TAPS; t++) begin
        src_re[t] = $signed(JOB_C[jb*TAPS+t][31:16]);
        src_im[t] = $signed(JOB_C[jb*TAPS+t][15:0]);
      end
      load_set("R5/R10 load pads");
      for (int i = 0; i < JOB_N; i++)
        sample($signed(JOB_X[jb*JOB_N+i][31:16]), $signed(JOB_X[jb*JOB_N+i][15:0]), "R2/R10 job");
      for (int i = 0; i < TAPS - 1; i++) sample(0, 0, "R2/R10 tail");
    end

    // R4: idle gaps between samples
    for (int i = 0; i < 4; i++) begin
      sample(300 * i - 200, 77 - 50 * i, "R4 gapped");
      idle("R4 gap");
      idle("R4 gap");
    end
    flush("R4 drain");

    // R6: stray chunks outside a window
    step(0, 1, 0, 0, 0, {LANES{16'h7abc}}, {LANES{16'h8123}}, "R6 stray");
    step(0, 1, 1, 0, 0, {LANES{16'h1111}}, {LANES{16'hf00f}}, "R6 stray");
    impulse("R6 taps kept");

    // R7: restart inside a window, coincident chunk dropped
    for (int t = 0; t < TAPS; t++) begin src_re[t] = 40 - 11 * t; src_im[t] = 3 * t - 9; end
    step(1, 0, 0, 0, 0, '0, '0, "R7 open");
    step(0, 1, 1, 0, 0, {LANES{16'h0bad}}, {LANES{16'hbeef}}, "R7 junk chunk");
    step(1, 1, 0, 0, 0, {LANES{16'h5a5a}}, {LANES{16'ha5a5}}, "R7 restart");
    for (int c = 0; c < CHUNKS; c++)
      step(0, 1, 1, 0, 0, pack_lane(c, 0), pack_lane(c, 1), "R7 reload");
    impulse("R7 taps");

    // R8: impulse enters in the cycle of the first chunk write
    flush("R8 drain");
    for (int t = 0; t < TAPS; t++) begin src_re[t] = 1000 + t; src_im[t] = -7 * t; end
    step(1, 0, 0, 0, 0, '0, '0, "R8 open");
    step(0, 1, 1, 16, 0, pack_lane(0, 0), pack_lane(0, 1), "R8 old tap0");
    step(0, 1, 1, 0, 0, pack_lane(1, 0), pack_lane(1, 1), "R8 new tap1");
    for (int i = 0; i < TAPS - 2; i++) sample(0, 0, "R8 rest");

    // R3: extreme operands
    for (int t = 0; t < TAPS; t++) begin src_re[t] = -32768; src_im[t] = 32767; end
    load_set("R3 load");
    for (int i = 0; i < TAPS; i++) sample(-32768, -32768, "R3 extreme");
    sample(32767, -32768, "R3 extreme");
    for (int i = 0; i < TAPS - 1; i++) sample(0, 0, "R3 tail");

    // R9: reset mid-stream clears history and taps
    sample(1234, -4321, "R9 pre");
    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R9 midreset valid", longint'(out_valid), 0);
    chk("R9 midreset re", longint'(out_re), 0);
    rst_n = 1;
    log_len = 0; m_busy = 0; m_cnt = 0;
    for (int t = 0; t < TAPS; t++) begin m_cre[t] = 0; m_cim[t] = 0; end
    sample(30000, -30000, "R9 cleared taps");
    sample(-5, 9, "R9 cleared taps");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule